// File: doc/BRIEF.md
# Six-Bit Wiper Position Counter with Step Mode

This block holds the position of one potentiometer wiper as a six-bit count and decodes that count into 64 one-hot tap enables. Tap enable 0 drives the low-end terminal and tap enable 63 drives the high-end terminal. The count changes in four ways:

- A direct write from the host.
- A parallel transfer from one of four stored register slots.
- Single steps while step mode is active.
- A recall of slot 0 when reset is released.

The count is volatile, so every load finishes on the next clock edge with no busy interval.

Step mode is armed by a one-cycle strobe from the command decoder once the increment/decrement command has been acknowledged. The bus front end supplies single-cycle events for SCL rising and falling edges, the SDA level, and START and STOP conditions. The SDA level at a rising SCL edge sets the direction of a step. The step itself is applied on the falling SCL edge that follows. A START or STOP ends step mode, so the clock pulse that carries the condition never moves the wiper.

Both load paths use valid/ready. Ready is low while reset is asserted and rises at the first clock edge with reset released. A beat is taken on any cycle where valid and ready are both high. Valid may be held for several cycles, and each cycle where both are high reloads the count. Nothing is taken while ready is low. Step and bus events are plain pins.

Top module: `wiper_pos_ctr`

## Requirements
- R1: While rst_n is low, the count follows slot 0 of dr_bank (bits 5:0), and wr_ready and xfr_ready are low. Once reset is released, the count keeps the recalled value. A load offered before ready rises is not taken, and a later change to slot 0 has no effect on the count.
- R2: tap_sel always has exactly one bit set, and that bit is at index count. Count 00h sets bit 0 (low end) and count 3Fh sets bit 63 (high end).
- R3: When wr_valid and wr_ready are both high at a clock edge, count equals wr_data after that edge.
- R4: When xfr_valid and xfr_ready are both high at a clock edge, count equals slot xfr_sel of dr_bank after that edge. Slot k occupies bits 6k+5:6k. There is no busy interval.
- R5: When a host write and a transfer are taken at the same edge, the host write wins.
- R6: A step_arm strobe makes step_active high after the next edge. A bus_start or bus_stop makes step_active low after the next edge. In the same cycle, a START or STOP wins over step_arm.
- R7: In step mode, the SDA level at an scl_rise event sets the direction of the step: 1 means up and 0 means down. The step is applied at the edge of the next scl_fall event, and it changes the count by exactly 1.
- R8: Stepping saturates. An up step at 3Fh leaves 3Fh, and a down step at 00h leaves 00h.
- R9: SCL pulses leave the count unchanged in two cases: outside step mode, and when a START or STOP comes between the rising and falling edge of a pulse.
- R10: When a load is taken in the same cycle as a step, the count takes the load value and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls slot 0 |
| dr_bank | input | 24 | Four stored 6-bit register slots, slot k at bits 6k+5:6k |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be taken |
| wr_data | input | 6 | Host write value |
| xfr_valid | input | 1 | Slot transfer offered |
| xfr_ready | output | 1 | Slot transfer can be taken |
| xfr_sel | input | 2 | Slot chosen for the transfer |
| step_arm | input | 1 | Enter step mode (one-cycle strobe) |
| scl_rise | input | 1 | SCL rising-edge event |
| scl_fall | input | 1 | SCL falling-edge event |
| sda_lvl | input | 1 | Sampled SDA level |
| bus_start | input | 1 | START condition event |
| bus_stop | input | 1 | STOP condition event |
| step_active | output | 1 | Step mode is active |
| count | output | 6 | Wiper position |
| tap_sel | output | 64 | One-hot tap enable |

## Verification
A wrong count shows up on count and tap_sel one clock edge after the load or falling SCL event that caused it, and every later comparison repeats the error until the next load. The direction latch is hidden state. If it is wrong, the count moves the wrong way at the next falling edge. If the pending flag survives a START or STOP, a count changes where none was expected at the first falling edge after the condition. A stuck step-mode flag is visible directly on step_active one edge after the arm or bus condition.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_cmd_e;
endpackage

// File: rtl/wpc_step_ctl.sv
module wpc_step_ctl
  import wpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_arm,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      sda_lvl,
  input  logic      bus_start,
  input  logic      bus_stop,
  output logic      active,
  output step_cmd_e step_cmd
);
  logic pend_q;
  logic dir_q;
  logic cond;

  assign cond = bus_start | bus_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (cond) begin
      active <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (step_arm) active <= 1'b1;
      if (active && scl_rise) begin
        pend_q <= 1'b1;
        dir_q  <= sda_lvl;
      end else if (scl_fall) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    step_cmd = STEP_NONE;
    if (active && pend_q && scl_fall && !cond)
      step_cmd = dir_q ? STEP_UP : STEP_DN;
  end

  // R6
  cond_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !active);
  // R6
  arm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_arm && !bus_start && !bus_stop) |=> active);
  // R9
  idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (step_cmd == STEP_NONE));
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter
  import wpc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] recall_val,
  input  logic             wr_fire,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             xfr_fire,
  input  logic [CNT_W-1:0] xfr_val,
  input  step_cmd_e        step_cmd,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                                     cnt <= recall_val;
    else if (wr_fire)                               cnt <= wr_val;
    else if (xfr_fire)                              cnt <= xfr_val;
    else if (step_cmd == STEP_UP && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    else if (step_cmd == STEP_DN && cnt != CNT_MIN) cnt <= cnt - 1'b1;
  end

  // R3
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> cnt == $past(wr_val));
  // R10
  xfr_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_fire && !wr_fire) |=> cnt == $past(xfr_val));
  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !xfr_fire && step_cmd == STEP_UP && cnt != CNT_MAX)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !xfr_fire && step_cmd == STEP_UP && cnt == CNT_MAX)
      |=> cnt == CNT_MAX);
  // R8
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !xfr_fire && step_cmd == STEP_DN && cnt == CNT_MIN)
      |=> cnt == CNT_MIN);
endmodule

// File: rtl/wpc_tap_dec.sv
module wpc_tap_dec #(
  parameter int CNT_W = 6,
  localparam int NUM_TAPS = 1 << CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cnt,
  output logic [NUM_TAPS-1:0] tap
);
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign tap[t] = (cnt == CNT_W'(t));
  end

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap) == 1);
  // R2
  tap_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap[cnt] == 1'b1);
endmodule

// File: rtl/wiper_pos_ctr.sv
module wiper_pos_ctr
  import wpc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int NUM_DR = 4,
  localparam int SEL_W    = $clog2(NUM_DR),
  localparam int NUM_TAPS = 1 << CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DR*CNT_W-1:0] dr_bank,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic                    xfr_valid,
  output logic                    xfr_ready,
  input  logic [SEL_W-1:0]        xfr_sel,
  input  logic                    step_arm,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    sda_lvl,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  output logic                    step_active,
  output logic [CNT_W-1:0]        count,
  output logic [NUM_TAPS-1:0]     tap_sel
);
  logic [CNT_W-1:0] slot [NUM_DR];
  logic             ready_q;
  logic             wr_fire;
  logic             xfr_fire;
  step_cmd_e        step_cmd;

  for (genvar s = 0; s < NUM_DR; s++) begin : g_slot
    assign slot[s] = dr_bank[s*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready  = ready_q;
  assign xfr_ready = ready_q;
  assign wr_fire   = wr_valid & ready_q;
  assign xfr_fire  = xfr_valid & ready_q;

  wpc_step_ctl u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_arm (step_arm),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .active   (step_active),
    .step_cmd (step_cmd)
  );

  wpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .recall_val(slot[0]),
    .wr_fire   (wr_fire),
    .wr_val    (wr_data),
    .xfr_fire  (xfr_fire),
    .xfr_val   (slot[xfr_sel]),
    .step_cmd  (step_cmd),
    .cnt       (count)
  );

  wpc_tap_dec #(.CNT_W(CNT_W)) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (count),
    .tap  (tap_sel)
  );

  // R5
  wr_over_xfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && xfr_fire) |=> count == $past(wr_data));
  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
endmodule

// File: tb/test_wiper_pos_ctr.sv
module test_wiper_pos_ctr;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [5:0] cnt;
    logic       act;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] dr_bank;
  logic        wr_valid = 1'b0, xfr_valid = 1'b0;
  logic        wr_ready, xfr_ready;
  logic [5:0]  wr_data = '0;
  logic [1:0]  xfr_sel = '0;
  logic        step_arm = 0, scl_rise = 0, scl_fall = 0, sda_lvl = 0;
  logic        bus_start = 0, bus_stop = 0;
  logic        step_active;
  logic [5:0]  count;
  logic [63:0] tap_sel;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t sb[$];
  logic [5:0] exp_cnt;
  logic       exp_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_pos_ctr i_wiper_pos_ctr (
    .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .xfr_valid(xfr_valid), .xfr_ready(xfr_ready), .xfr_sel(xfr_sel),
    .step_arm(step_arm), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .bus_start(bus_start), .bus_stop(bus_stop),
    .step_active(step_active), .count(count), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.cnt = exp_cnt;
    e.act = exp_act;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares queued expectations at the falling clock edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(count == e.cnt, {e.tag, " count"}, count, e.cnt);
        // R2 tap position follows count
        chk(tap_sel == (64'd1 << e.cnt), "R2 tap_sel", 0, 0);
        chk(step_active == e.act, {e.tag, " step_active"}, step_active, e.act);
      end
    end
  end

  task automatic host_wr(input logic [5:0] v);
    wr_valid = 1; wr_data = v; tick(); wr_valid = 0;
  endtask

  task automatic xfr(input logic [1:0] s);
    xfr_valid = 1; xfr_sel = s; tick(); xfr_valid = 0;
  endtask

  task automatic pulse(input logic sda);
    sda_lvl = sda; scl_rise = 1; tick(); scl_rise = 0;
    tick();
    scl_fall = 1; tick(); scl_fall = 0;
  endtask

  task automatic arm();
    step_arm = 1; tick(); step_arm = 0;
  endtask

  initial begin
    dr_bank = {6'h00, 6'h3F, 6'h05, 6'h2A};
    repeat (3) tick();
    // R1 reset state
    chk(wr_ready == 0 && xfr_ready == 0, "R1 ready in reset", wr_ready, 0);
    exp_cnt = 6'h2A; exp_act = 0; push("R1 recall");
    tick();
    rst_n = 1; wr_valid = 1; wr_data = 6'h01;
    chk(wr_ready == 0, "R1 ready before first edge", wr_ready, 0);
    tick(); wr_valid = 0;
    chk(wr_ready == 1 && xfr_ready == 1, "R1 ready after release", wr_ready, 1);
    push("R1 early load not taken");
    dr_bank[5:0] = 6'h11; tick(); tick();
    push("R1 slot0 change ignored");
    // R3 host writes at both ends
    host_wr(6'h3F); exp_cnt = 6'h3F; push("R3 write 3F");
    host_wr(6'h00); exp_cnt = 6'h00; push("R3 write 00");
    // R4 transfers
    xfr(2'd1); exp_cnt = 6'h05; push("R4 xfr slot1");
    xfr(2'd2); exp_cnt = 6'h3F; push("R4 xfr slot2");
    // R5 both at once
    wr_valid = 1; wr_data = 6'h10; xfr_valid = 1; xfr_sel = 2'd1; tick();
    wr_valid = 0; xfr_valid = 0; exp_cnt = 6'h10; push("R5 write beats xfr");
    // R9 pulses outside step mode
    pulse(1); push("R9 idle pulse");
    // R6 enter
    arm(); exp_act = 1; push("R6 arm");
    // R7 steps
    pulse(1); exp_cnt = 6'h11; push("R7 step up");
    pulse(1); exp_cnt = 6'h12; push("R7 step up again");
    pulse(0); exp_cnt = 6'h11; push("R7 step down");
    // R8 saturation
    host_wr(6'h3F); exp_cnt = 6'h3F; push("R8 preset top");
    pulse(1); push("R8 saturate top");
    host_wr(6'h00); exp_cnt = 6'h00; push("R8 preset bottom");
    pulse(0); push("R8 saturate bottom");
    // R10 transfer in the same cycle as a step
    host_wr(6'h10); exp_cnt = 6'h10;
    sda_lvl = 1; scl_rise = 1; tick(); scl_rise = 0;
    scl_fall = 1; xfr_valid = 1; xfr_sel = 2'd3; tick();
    scl_fall = 0; xfr_valid = 0; exp_cnt = 6'h00; push("R10 load beats step");
    // R9 stop in the middle of a pulse
    host_wr(6'h20); exp_cnt = 6'h20;
    sda_lvl = 1; scl_rise = 1; tick(); scl_rise = 0;
    bus_stop = 1; tick(); bus_stop = 0; exp_act = 0; push("R6 stop clears");
    scl_fall = 1; tick(); scl_fall = 0; push("R9 interrupted pulse");
    // R6 start ends mode; start wins over arm
    arm(); exp_act = 1; push("R6 re-arm");
    bus_start = 1; tick(); bus_start = 0; exp_act = 0; push("R6 start clears");
    step_arm = 1; bus_start = 1; tick(); step_arm = 0; bus_start = 0;
    push("R6 start beats arm");
    pulse(0); push("R9 pulse after start");
    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule